// File: doc/BRIEF.md
# Sequenced Four-Function Arithmetic Unit

This block is a small signed arithmetic unit with its own sequencer. Both 8-bit operands enter through a single input bus, one after the other, and the unit then adds, subtracts, multiplies or divides them. Add and subtract are done in one pass through an adder. Multiply uses eight shift-and-add steps and fixes up a negative multiplier in its last step. Divide uses eight restoring steps on the operand magnitudes.

Results leave through a registered output bus with a one-cycle valid pulse per word. Add and subtract deliver one word. Multiply and divide deliver two words on consecutive cycles. A host starts an operation with a one-cycle start strobe, then drives operand A with the opcode, then operand B, and then waits a fixed number of cycles for the result.

Top module: `seq_alu`

## Requirements
- R1: Edge 0 is the rising edge at which `start` is sampled high while the unit is idle. On edge 1 the unit captures `din` as operand A and captures `op` with it. On edge 2 it captures `din` as operand B. `din` and `op` have no effect at any other edge.
- R2: Opcode 2'b00 adds. Edge 4 loads (A + B) mod 256 onto `dout`.
- R3: Opcode 2'b01 subtracts. Edge 4 loads (A − B) mod 256, formed as A plus inverted B plus a carry-in of 1.
- R4: Opcode 2'b10 multiplies A by B as two's-complement numbers into a 16-bit product. Edge 11 loads the low byte and edge 12 loads the high byte.
- R5: When the multiplier B is negative, its sign bit is handled in the final iteration by adding the inverted multiplicand plus 1, so the product stays correctly signed. This holds for every operand combination, including −128 × −128 = 16384.
- R6: Opcode 2'b11 divides |A| by |B| as unsigned magnitudes. Edge 11 loads the quotient and edge 12 loads the remainder.
- R7: A divide with B = 0 yields a quotient of 8'hFF and a remainder equal to |A| mod 256.
- R8: `dvalid` is high for exactly the one cycle after each edge that loads a result word, and low at all other times. Add and subtract give one word. Multiply and divide give two words, on back-to-back cycles.
- R9: `start` is ignored from edge 1 until the edge that loads the final result word, and changes on `din` and `op` in that window do not alter the result.
- R10: `restart`, sampled high at an edge, returns the unit to idle, aborts any operation and clears `dout` to 0 and `dvalid` to 0. No word from the aborted operation appears afterwards.
- R11: A new `start` is accepted at the first edge after the edge that loads the final result word, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| restart | input | 1 | Synchronous active-high return to idle |
| start | input | 1 | One-cycle strobe that begins an operation |
| din | input | 8 | Shared operand bus: A, then B |
| op | input | 2 | Opcode, sampled together with operand A |
| dout | output | 8 | Registered result word |
| dvalid | output | 1 | High for one cycle with each result word |

## Verification
Counting the start edge as edge 0, the single word from add or subtract is due after edge 4. The two words from multiply or divide are due after edges 11 and 12. The bench drives stimulus on falling edges and samples `dvalid` on every falling edge of each operation, so an early, late, missing or extra word is seen in the exact cycle it appears. `dout` is compared only where a word is due. Runs that toggle `start`, `din` and `op` inside the busy window, and runs that chain the next start onto the final word's edge, use the same per-cycle schedule.

// File: rtl/seq_alu.sv
module seq_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         restart,
  input  logic         start,
  input  logic [W-1:0] din,
  input  logic [1:0]   op,
  output logic [W-1:0] dout,
  output logic         dvalid
);
  localparam int CW = $clog2(W);

  typedef enum logic [2:0] {
    S_IDLE, S_GETA, S_GETB, S_ADD, S_MUL, S_DIV, S_OUT1, S_OUT2
  } st_t;

  st_t          st;
  logic [1:0]   opq;
  logic [W-1:0] aq, bq, lo;
  logic [W:0]   hi;
  logic [CW-1:0] cnt;

  function automatic logic [W-1:0] mag(input logic [W-1:0] x);
    return x[W-1] ? (~x + W'(1)) : x;
  endfunction

  wire last = (cnt == CW'(W-1));

  // multiply step: add or (last step, negative multiplier) subtract the multiplicand
  wire         fix   = last && lo[0];
  wire [W:0]   a_ext = {aq[W-1], aq};
  wire [W:0]   madd  = lo[0] ? (fix ? ~a_ext : a_ext) : '0;
  wire [W:0]   msum  = hi + madd + (W+1)'(fix);

  // add / subtract through one adder
  wire [W-1:0] addsub = aq + (opq[0] ? ~bq : bq) + W'(opq[0]);

  // restoring divide step
  wire [W:0]   dshift = {hi[W-1:0], lo[W-1]};
  wire [W+1:0] dtrial = {1'b0, dshift} - {2'b00, bq};
  wire         dfit   = !dtrial[W+1];

  always_ff @(posedge clk) begin
    if (restart) begin
      st     <= S_IDLE;
      opq    <= '0;
      aq     <= '0;
      bq     <= '0;
      lo     <= '0;
      hi     <= '0;
      cnt    <= '0;
      dout   <= '0;
      dvalid <= 1'b0;
    end else begin
      dvalid <= 1'b0;
      case (st)
        S_IDLE: if (start) st <= S_GETA;
        S_GETA: begin
          aq  <= din;
          opq <= op;
          st  <= S_GETB;
        end
        S_GETB: begin
          cnt <= '0;
          hi  <= '0;
          case (opq)
            2'b10: begin lo <= din;     bq <= din;      st <= S_MUL; end
            2'b11: begin lo <= mag(aq); bq <= mag(din); st <= S_DIV; end
            default: begin              bq <= din;      st <= S_ADD; end
          endcase
        end
        S_ADD: begin
          lo <= addsub;
          st <= S_OUT1;
        end
        S_MUL: begin
          hi  <= {msum[W], msum[W:1]};
          lo  <= {msum[0], lo[W-1:1]};
          cnt <= cnt + CW'(1);
          if (last) st <= S_OUT1;
        end
        S_DIV: begin
          hi  <= dfit ? dtrial[W:0] : dshift;
          lo  <= {lo[W-2:0], dfit};
          cnt <= cnt + CW'(1);
          if (last) st <= S_OUT1;
        end
        S_OUT1: begin
          dout   <= lo;
          dvalid <= 1'b1;
          st     <= opq[1] ? S_OUT2 : S_IDLE;
        end
        S_OUT2: begin
          dout   <= hi[W-1:0];
          dvalid <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CAPTURE_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (restart)
    (st == S_GETA) |-> $past(st == S_IDLE && start)); // R9

  AST_ONE_WORD_ADDSUB: assert property (@(posedge clk) disable iff (restart)
    (st == S_OUT1 && !opq[1]) |=> (dvalid && st == S_IDLE)); // R8

  AST_TWO_WORDS_MULDIV: assert property (@(posedge clk) disable iff (restart)
    (st == S_OUT1 && opq[1]) |=> (dvalid && st == S_OUT2)); // R8

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (restart)
    dvalid |-> ($past(st) == S_OUT1 || $past(st) == S_OUT2)); // R8

  AST_ITERATION_COUNT: assert property (@(posedge clk) disable iff (restart)
    (st == S_OUT1 && $past(st) != S_ADD) |-> $past(cnt) == CW'(W-1)); // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk)
    restart |=> (st == S_IDLE && !dvalid && dout == '0)); // R10
endmodule

// File: tb/sim_seq_alu.sv
module sim_seq_alu;
  logic       clk = 1'b0;
  logic       restart = 1'b1;
  logic       start = 1'b0;
  logic [7:0] din = '0;
  logic [1:0] op = '0;
  logic [7:0] dout;
  logic       dvalid;

  int checks = 0;
  int errors = 0;
  bit pend = 1'b0;

  always #10 clk = ~clk;

  seq_alu #(.W(8)) u0 (
    .clk(clk), .restart(restart), .start(start),
    .din(din), .op(op), .dout(dout), .dvalid(dvalid)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input int a, input int b,
                     input bit noise, input bit chain);
    int p, ma, mb, nw, last;
    logic [7:0] w0, w1;
    string tag;
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    case (o)
      2'b00: begin w0 = 8'(a + b); w1 = '0; nw = 1; tag = "R2"; end
      2'b01: begin w0 = 8'(a - b); w1 = '0; nw = 1; tag = "R3"; end
      2'b10: begin
        p = a * b; w0 = p[7:0]; w1 = p[15:8]; nw = 2;
        tag = (b < 0) ? "R5" : "R4";
      end
      default: begin
        nw = 2;
        if (mb == 0) begin w0 = 8'hFF; w1 = 8'(ma); tag = "R7"; end
        else begin w0 = 8'(ma / mb); w1 = 8'(ma % mb); tag = "R6"; end
      end
    endcase
    if (noise) tag = {tag, " R9"};
    if (pend)  tag = {tag, " R11"};
    tag = {tag, " R1"};
    last = (nw == 1) ? 5 : 13;
    if (!pend) begin
      @(negedge clk) start = 1'b1;
    end
    @(negedge clk) start = 1'b0; din = a[7:0]; op = o;
    @(negedge clk) din = b[7:0];
    for (int k = 3; k <= last; k++) begin
      @(negedge clk);
      din = 8'(k * 37 + a);
      op  = ~o;
      start = (k == last) ? chain : (noise && k < last);
      if (nw == 1) begin
        chk("R8 valid", 16'(dvalid), 16'(k == 5));
        if (k == 5) chk(tag, 16'(dout), 16'(w0));
      end else begin
        chk("R8 valid", 16'(dvalid), 16'(k == 12 || k == 13));
        if (k == 12) chk(tag, 16'(dout), 16'(w0));
        if (k == 13) chk(tag, 16'(dout), 16'(w1));
      end
    end
    pend = chain;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int vals[16] = '{-128, -127, -100, -64, -2, -1, 0, 1, 2, 3, 7, 64, 85, 100, 126, 127};

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset dvalid", 16'(dvalid), 16'd0);
    chk("R10 reset dout", 16'(dout), 16'd0);
    restart = 1'b0;

    for (int a = -128; a < 128; a++) begin
      run(2'b00, a, 3 * a + 1, a % 7 == 0, a % 4 == 0);
      run(2'b01, a, 127 - 2 * a, a % 5 == 0, a % 3 == 0);
    end
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int o = 0; o < 4; o++)
          run(2'(o), vals[i], vals[j], (i + j + o) % 5 == 0, (i * 3 + j + o) % 4 == 0);
    run(2'b11, -128, 0, 1'b0, 1'b0);
    run(2'b10, -128, -128, 1'b0, 1'b0);

    // R10: abort a multiply mid-run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0; din = 8'd100; op = 2'b10;
    @(negedge clk) din = 8'd77;
    repeat (3) @(negedge clk);
    restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    for (int k = 0; k < 14; k++) begin
      chk("R10 abort dvalid", 16'(dvalid), 16'd0);
      chk("R10 abort dout", 16'(dout), 16'd0);
      @(negedge clk);
    end
    run(2'b11, 100, 7, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule